// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits between a set of peripheral interrupt sources and a processor core. It collects their requests and offers the core one request at a time. Each source has its own pending latch and enable bit. A fixed priority picks the winner: the lowest source index wins. The block drives the winner's index on `vector` and raises `irq` when the core may take it. The core answers with `ack` when it enters a handler and with `ret` when it leaves one.

Each source has a nesting bit, sampled when that source is granted.

- **Nesting bit 0 (sequential handler):** granting the source clears the global enable. Every other request then waits until the handler returns. The return sets the global enable again.
- **Nesting bit 1 (nested handler):** the global enable stays set. A request with a strictly higher priority than the highest active level can preempt the handler at once. The handler resumes when the preempting handler returns.

The block keeps a bitmask of active levels to track this nesting. Software can also force the global enable on or off through two strobes.

A small state machine follows the kind of handler at the top of the active stack:

- **`ST_IDLE`:** no handler is active.
- **`ST_SEQ`:** the innermost handler is sequential.
- **`ST_NEST`:** the innermost handler is nested.

Its transitions are:

- **grant** (`ack` while `irq`): from any state to `ST_SEQ` or `ST_NEST`, chosen by the granted source's nesting bit.
- **return** (`ret` with a handler active): to `ST_IDLE` when the mask empties. Otherwise it goes to the state that matches the handler now at the top.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pending latch set by a one-cycle pulse on `req[i]` stays set until source i is granted, including while other handlers run, whatever the global enable.
- R2: `vector` shows the lowest index among sources that are both pending and enabled, and shows 0 when there is none.
- R3: The global enable `gie` is 0 after reset. `gie_set` sets it and `gie_clr` clears it, and `gie_clr` wins when both are strobed together. `irq` is never 1 while `gie` is 0.
- R4: Granting a source whose nesting bit is 0 clears `gie` on the grant edge. The `ret` that ends that handler sets `gie` again. A request that arrived meanwhile raises `irq` right after that `ret`.
- R5: Granting a source whose nesting bit is 1 leaves `gie` set. While handlers are active, `irq` rises only for a candidate whose index is strictly lower than the lowest active index.
- R6: `active_lvl` bit i is set by a grant of source i. `ret` clears the lowest-index set bit. `ack` while `irq` is 0 is ignored. `ret` with an empty mask is ignored. `ret` in the same cycle as a grant is ignored.
- R7: A grant clears the granted source's pending latch. A request from that same source in the grant cycle leaves the latch set.
- R8: A pending source whose `en` bit is 0 neither raises `irq` nor appears on `vector`, and it stays pending until enabled.
- R9: Reset clears all pending latches, the active mask and `gie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SRC | Request pulses, one per source |
| en | input | N_SRC | Per-source enable |
| nest_mode | input | N_SRC | Per-source handler kind: 1 nested, 0 sequential |
| ack | input | 1 | Core enters the handler for `vector` |
| ret | input | 1 | Core leaves the innermost handler |
| gie_set | input | 1 | Software strobe setting the global enable |
| gie_clr | input | 1 | Software strobe clearing the global enable |
| irq | output | 1 | Request offered to the core |
| vector | output | $clog2(N_SRC) | Index of the winning candidate |
| gie | output | 1 | Global enable |
| active_lvl | output | N_SRC | Mask of active handler levels |

## Verification
The assertions watch several properties on every cycle:

- pending latches hold until cleared by a grant;
- `irq` never rises without the global enable;
- a raised `irq` always points at an enabled, pending source that outranks every active level;
- a sequential grant clears the enable, and a nested one keeps it;
- the state machine is idle exactly when the active mask is empty.

Only the bench scenarios can show the end-to-end orderings:

- a request that waited through a sequential handler is the next one offered;
- a preempted nested handler is returned to in the right order, including when the preempting handler is sequential;
- the same-cycle request and grant leaves the latch set;
- a disabled source is still pending once it is enabled.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEQ  = 2'd1,
        ST_NEST = 2'd2
    } svc_state_e;
endpackage

// File: rtl/prio_irq_pick.sv
// Lowest-index-first selector: index, one-hot and found flag.
module prio_irq_pick #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_oh
            if (g == 0) begin : g_first
                assign onehot[g] = bits[g];
            end else begin : g_rest
                assign onehot[g] = bits[g] & ~(|bits[g-1:0]);
            end
        end
    endgenerate

    assign found = |bits;

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prio_irq_pend.sv
// Per-source pending latches; set by request, cleared by grant.
module prio_irq_pend #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)       pend[g] <= 1'b0;
                else if (req[g])  pend[g] <= 1'b1;
                else if (clr[g])  pend[g] <= 1'b0;
            end

            AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[g] && !clr[g]) |=> pend[g]); // R1
            AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                req[g] |=> pend[g]); // R7
        end
    endgenerate
endmodule

// File: rtl/prio_irq_fsm.sv
// Service tracker: state, global enable, active levels, irq decision.
module prio_irq_fsm
    import prio_irq_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    input  logic          ret,
    input  logic          gie_set,
    input  logic          gie_clr,
    input  logic [W-1:0]  nest_mode,
    input  logic          cand_found,
    input  logic [IW-1:0] cand_idx,
    input  logic [W-1:0]  cand_oh,
    input  logic [IW-1:0] top_idx,
    input  logic [W-1:0]  top_oh,
    input  logic          nxt_found,
    input  logic [IW-1:0] nxt_idx,
    output logic          irq,
    output logic          grant,
    output logic          gie,
    output logic [W-1:0]  active
);
    svc_state_e   state, state_nx;
    logic [W-1:0] seq_flag;
    logic         do_ret;
    logic         grant_seq;

    // output / decision process
    always_comb begin
        irq = 1'b0;
        unique case (state)
            ST_IDLE:         irq = cand_found && gie;
            ST_SEQ, ST_NEST: irq = cand_found && gie && (cand_idx < top_idx);
            default:         irq = 1'b0;
        endcase
    end

    assign grant     = ack && irq;
    assign grant_seq = grant && !nest_mode[cand_idx];
    assign do_ret    = ret && !grant && (state != ST_IDLE);

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (grant) state_nx = grant_seq ? ST_SEQ : ST_NEST;
            end
            ST_SEQ, ST_NEST: begin
                if (grant)       state_nx = grant_seq ? ST_SEQ : ST_NEST;
                else if (do_ret) state_nx = !nxt_found ? ST_IDLE :
                                            (seq_flag[nxt_idx] ? ST_SEQ : ST_NEST);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= '0;
            seq_flag <= '0;
        end else if (grant) begin
            active   <= active | cand_oh;
            seq_flag <= (seq_flag & ~cand_oh) | (grant_seq ? cand_oh : '0);
        end else if (do_ret) begin
            active   <= active & ~top_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              gie <= 1'b0;
        else if (gie_clr)                        gie <= 1'b0;
        else if (grant_seq)                      gie <= 1'b0;
        else if (gie_set)                        gie <= 1'b1;
        else if (do_ret && seq_flag[top_idx])    gie <= 1'b1;
    end

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie); // R3
    AST_SEQ_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !nest_mode[cand_idx]) |=> !gie); // R4
    AST_NEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && nest_mode[cand_idx] && !gie_clr) |=> gie); // R5
    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (active != '0)) |-> (cand_idx < top_idx)); // R5
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) == (active == '0)); // R6
    AST_GRANT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> active[$past(cand_idx)]); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_SRC = 8,
    localparam int VW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] nest_mode,
    input  logic             ack,
    input  logic             ret,
    input  logic             gie_set,
    input  logic             gie_clr,
    output logic             irq,
    output logic [VW-1:0]    vector,
    output logic             gie,
    output logic [N_SRC-1:0] active_lvl
);
    logic [N_SRC-1:0] pend, cand_bits, cand_oh, top_oh, nxt_oh, clr, rest;
    logic             cand_found, top_found, nxt_found, grant;
    logic [VW-1:0]    cand_idx, top_idx, nxt_idx;

    assign cand_bits = pend & en;
    assign clr       = grant ? cand_oh : '0;
    assign rest      = active_lvl & ~top_oh;
    assign vector    = cand_idx;

    prio_irq_pend #(.W(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(req), .clr(clr), .pend(pend)
    );

    prio_irq_pick #(.W(N_SRC), .IW(VW)) u_cand (
        .bits(cand_bits), .found(cand_found), .idx(cand_idx), .onehot(cand_oh)
    );
    prio_irq_pick #(.W(N_SRC), .IW(VW)) u_top (
        .bits(active_lvl), .found(top_found), .idx(top_idx), .onehot(top_oh)
    );
    prio_irq_pick #(.W(N_SRC), .IW(VW)) u_next (
        .bits(rest), .found(nxt_found), .idx(nxt_idx), .onehot(nxt_oh)
    );

    prio_irq_fsm #(.W(N_SRC), .IW(VW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack(ack), .ret(ret),
        .gie_set(gie_set), .gie_clr(gie_clr), .nest_mode(nest_mode),
        .cand_found(cand_found), .cand_idx(cand_idx), .cand_oh(cand_oh),
        .top_idx(top_idx), .top_oh(top_oh),
        .nxt_found(nxt_found), .nxt_idx(nxt_idx),
        .irq(irq), .grant(grant), .gie(gie), .active(active_lvl)
    );

    AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en[vector] && pend[vector])); // R8
    AST_TOP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        top_found == (active_lvl != '0)); // R6
    AST_NXT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_found |-> ((nxt_oh & active_lvl) != '0)); // R6
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int N  = 8;
    localparam int NS = 35;

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] en;
        logic [7:0] nest;
        logic       ack;
        logic       ret;
        logic       gset;
        logic       gclr;
        logic       e_irq;
        logic [2:0] e_vec;
        logic       e_gie;
        logic [7:0] e_act;
    } step_t;

    // req en nest ack ret gset gclr | irq vec gie act
    localparam step_t TBL [NS] = '{
        '{8'h00,8'hFF,8'h00,1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0,1'b1,8'h00}, // 0  R3 enable
        '{8'h0C,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd2,1'b1,8'h00}, // 1  R2 lowest wins
        '{8'h00,8'hFF,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd3,1'b0,8'h04}, // 2  R4 R7 seq grant
        '{8'h01,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h04}, // 3  R1 waits
        '{8'h00,8'hFF,8'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd0,1'b1,8'h00}, // 4  R4 restore
        '{8'h00,8'hFF,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd3,1'b0,8'h01}, // 5  R1
        '{8'h00,8'hFF,8'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd3,1'b1,8'h00}, // 6  R4
        '{8'h00,8'hFF,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h08}, // 7  R6
        '{8'h00,8'hFF,8'h00,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00}, // 8  R6
        '{8'h20,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd5,1'b1,8'h00}, // 9  R5
        '{8'h00,8'hFF,8'hFF,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h20}, // 10 R5 gie kept
        '{8'h80,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd7,1'b1,8'h20}, // 11 R5 lower blocked
        '{8'h02,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd1,1'b1,8'h20}, // 12 R5 preempt
        '{8'h00,8'hFF,8'hFF,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd7,1'b1,8'h22}, // 13 R6 nest
        '{8'h00,8'hFF,8'hFF,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd7,1'b1,8'h20}, // 14 R6 resume
        '{8'h00,8'hFF,8'hFF,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd7,1'b1,8'h00}, // 15 R1
        '{8'h00,8'hFF,8'hFF,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h80}, // 16 R7
        '{8'h80,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd7,1'b1,8'h80}, // 17 R5 equal blocked
        '{8'h00,8'hFF,8'hFF,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd7,1'b1,8'h00}, // 18 R5
        '{8'h80,8'hFF,8'hFF,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd7,1'b1,8'h80}, // 19 R7 same cycle
        '{8'h00,8'hFF,8'hFF,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd7,1'b1,8'h00}, // 20 R7
        '{8'h00,8'h7F,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00}, // 21 R8 masked
        '{8'h00,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd7,1'b1,8'h00}, // 22 R8 still pending
        '{8'h00,8'hFF,8'hFF,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd7,1'b0,8'h00}, // 23 R3 clear
        '{8'h00,8'hFF,8'hFF,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd7,1'b0,8'h00}, // 24 R6 ack ignored
        '{8'h00,8'hFF,8'hFF,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd7,1'b0,8'h00}, // 25 R6 ret ignored
        '{8'h00,8'hFF,8'hFF,1'b0,1'b0,1'b1,1'b0, 1'b1,3'd7,1'b1,8'h00}, // 26 R3 set
        '{8'h00,8'hFF,8'hFF,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h80}, // 27 R6
        '{8'h00,8'hFF,8'hFF,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00}, // 28 R6
        '{8'h10,8'hFF,8'hFD,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd4,1'b1,8'h00}, // 29 R2
        '{8'h00,8'hFF,8'hFD,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h10}, // 30 R5
        '{8'h02,8'hFF,8'hFD,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd1,1'b1,8'h10}, // 31 R5
        '{8'h00,8'hFF,8'hFD,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h12}, // 32 R4 seq in nest
        '{8'h00,8'hFF,8'hFD,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h10}, // 33 R4 restore
        '{8'h00,8'hFF,8'hFD,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00}  // 34 R6 empty
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req, en, nest_mode, active_lvl;
    logic         ack, ret, gie_set, gie_clr, irq, gie;
    logic [2:0]   vector;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .en(en), .nest_mode(nest_mode),
        .ack(ack), .ret(ret), .gie_set(gie_set), .gie_clr(gie_clr),
        .irq(irq), .vector(vector), .gie(gie), .active_lvl(active_lvl)
    );

    function automatic string tag_of(int s);
        if (s == 0 || s == 23 || s == 26)            return "R3";
        if (s == 1 || s == 29)                       return "R2";
        if (s == 2 || s == 4 || s == 6 || s == 32 || s == 33) return "R4";
        if (s == 3 || s == 5 || s == 15)             return "R1";
        if ((s >= 9 && s <= 12) || s == 17 || s == 18 || s == 30 || s == 31) return "R5";
        if (s == 16 || s == 19 || s == 20)           return "R7";
        if (s == 21 || s == 22)                      return "R8";
        return "R6";
    endfunction

    task automatic check_out(string tag, logic e_irq, logic [2:0] e_vec,
                             logic e_gie, logic [7:0] e_act);
        checks++;
        if (irq !== e_irq || vector !== e_vec || gie !== e_gie || active_lvl !== e_act) begin
            errors++;
            $display("FAIL %s irq/vec/gie/act got %b/%0d/%b/%h expected %b/%0d/%b/%h",
                     tag, irq, vector, gie, active_lvl, e_irq, e_vec, e_gie, e_act);
        end
    endtask

    task automatic clear_strobes();
        req = '0; ack = 1'b0; ret = 1'b0; gie_set = 1'b0; gie_clr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; en = '0; nest_mode = '0;
        clear_strobes();
        repeat (3) @(posedge clk);
        #2;
        check_out("R9 reset", 1'b0, 3'd0, 1'b0, 8'h00);
        check_out("R3 reset gie", 1'b0, 3'd0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            req = TBL[s].req; en = TBL[s].en; nest_mode = TBL[s].nest;
            ack = TBL[s].ack; ret = TBL[s].ret;
            gie_set = TBL[s].gset; gie_clr = TBL[s].gclr;
            @(posedge clk);
            #2 clear_strobes();
            #2 check_out(tag_of(s), TBL[s].e_irq, TBL[s].e_vec, TBL[s].e_gie, TBL[s].e_act);
        end

        // R3: clear wins over set in the same cycle
        @(negedge clk);
        gie_set = 1'b1; gie_clr = 1'b1;
        @(posedge clk);
        #2 clear_strobes();
        #2 check_out("R3 clr beats set", 1'b0, 3'd0, 1'b0, 8'h00);

        // R1: request latched while gie is low, offered once enabled
        @(negedge clk);
        req = 8'h40; nest_mode = 8'h00;
        @(posedge clk);
        #2 clear_strobes();
        #2 check_out("R1 latched masked", 1'b0, 3'd6, 1'b0, 8'h00);
        @(negedge clk);
        gie_set = 1'b1;
        @(posedge clk);
        #2 clear_strobes();
        #2 check_out("R1 offered later", 1'b1, 3'd6, 1'b1, 8'h00);

        // R9: reset in the middle of a handler clears everything
        @(negedge clk);
        ack = 1'b1; req = 8'h01;
        @(posedge clk);
        #2 clear_strobes();
        #2 check_out("R9 pre-reset", 1'b0, 3'd0, 1'b0, 8'h40);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #4 check_out("R9 mid reset", 1'b0, 3'd0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1; gie_set = 1'b1;
        @(posedge clk);
        #2 clear_strobes();
        #2 check_out("R9 pend cleared", 1'b0, 3'd0, 1'b1, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule